// File: doc/BRIEF.md
# Test Access Port Controller with Boundary-Scan Instruction Decode

This block is a test access port controller in the IEEE 1149.1 style. A tester clocks it on `tck` and steers it through a 16-state machine with `tms`. It shifts a 4-bit instruction in from `tdi` and uses that instruction to decide which data path feeds `tdo`. The paths are a one-bit bypass stage, a 32-bit identification register, the return of an external boundary-scan chain, or the return of a secondary scan host.

From the current instruction the block also derives control lines for the boundary cells. These are chain select, host select, output hold-off, core-side and pin-side steering, and pulse/train test modes. It drives capture, shift and update strobes to the chain only while the chain is selected. The current state is exported as a 4-bit code and as an active-low reset indication.

Top module: `tap_ctrl`

## Requirements
- R1: The controller state follows the standard 16-state TMS graph on each rising `tck`. `state_code` carries these codes (hex): Test-Logic-Reset F, Run-Test/Idle C. On the DR branch: Select 7, Capture 6, Shift 2, Exit1 1, Pause 3, Exit2 0, Update 5. On the IR branch: Select 4, Capture E, Shift A, Exit1 9, Pause B, Exit2 8, Update D.
- R2: `trst_n` low at a rising edge forces Test-Logic-Reset. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state. Test-Logic-Reset makes the active instruction IDCODE (1000).
- R3: In Capture-IR the instruction shift stage loads 0001. In Shift-IR it shifts right with `tdi` entering the MSB, and `tdo` presents its LSB.
- R4: The active instruction changes only on the rising edge leaving Update-IR, or through reset. Decode outputs stay unchanged while a new value is being shifted.
- R5: Outside the IR branch, `tdo` is driven as follows. Opcodes 0001..0101 give `chain_ret`. Opcode 0111 gives `host_ret`. Opcode 1000 gives the ID register LSB. Every other code (1111, 0000, 0110 and undefined codes) gives the bypass stage.
- R6: The bypass stage captures 0 in Capture-DR and delays `tdi` by one shift.
- R7: The ID register captures 32'h00000001 and shifts out LSB first.
- R8: `chain_sel` is high for opcodes 0001, 0010, 0011, 0100 and 0101. `host_sel` is high only for 0111.
- R9: `hold_off` is high only for 0110. `core_from_jtag` is high only for 0100. `pins_from_jtag` is high for 0000, 0001, 0010, 0011 and 0110. `pulse_mode` is high only for 0010, and `train_mode` only for 0011.
- R10: `chain_capture`, `chain_shift` and `chain_update` are high in Capture-DR, Shift-DR and Update-DR respectively, and only while `chain_sel` is high.
- R11: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only after a falling edge seen in Shift-DR or Shift-IR.
- R12: `tlr_n` is low exactly while the state is Test-Logic-Reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, sampled on rising tck |
| tms | input | 1 | Mode select steering the state machine |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, falling-edge timed |
| tdo_oe | output | 1 | TDO drive enable, active high |
| chain_ret | input | 1 | Serial return of the boundary chain |
| host_ret | input | 1 | Serial return of the secondary scan host |
| chain_sel | output | 1 | Boundary chain selected |
| host_sel | output | 1 | Secondary host selected |
| chain_capture | output | 1 | Capture strobe to boundary chain |
| chain_shift | output | 1 | Shift strobe to boundary chain |
| chain_update | output | 1 | Update strobe to boundary chain |
| tlr_n | output | 1 | Low while in Test-Logic-Reset |
| state_code | output | 4 | Encoded current state |
| hold_off | output | 1 | Force pin outputs disabled |
| core_from_jtag | output | 1 | Core inputs taken from boundary cells |
| pins_from_jtag | output | 1 | Pin outputs taken from boundary cells |
| pulse_mode | output | 1 | Pulse-style external test active |
| train_mode | output | 1 | Train-style external test active |

## Verification
`state_code`, the decode lines and the chain strobes change one rising edge after the `tms` value that moves the state, because only the state and instruction registers lie in their path. `tdo` and `tdo_oe` follow at the next falling edge, half a cycle later. The bench drives `tms` and `tdi` 1 ns after a falling edge. It checks the state-derived outputs there, after the rising edge that acted on the previous inputs. It reads `tdo` at that same point, which is exactly where a tester would sample it on the coming rising edge. A serial result is therefore attributed to the shift step in which it is read. Every opcode value and a long pseudo-random TMS walk are swept, each against a reference computed in the bench.

// File: rtl/tap_ctrl_pkg.sv
// Shared types for the test access port controller: state codes, opcodes,
// decoded instruction record. Assumes a fixed 4-bit instruction.
package tap_ctrl_pkg;

    localparam int IR_W = 4;

    typedef enum logic [3:0] {
        ST_RESET    = 4'hF,
        ST_IDLE     = 4'hC,
        ST_DR_SEL   = 4'h7,
        ST_DR_CAP   = 4'h6,
        ST_DR_SHIFT = 4'h2,
        ST_DR_EX1   = 4'h1,
        ST_DR_PAUSE = 4'h3,
        ST_DR_EX2   = 4'h0,
        ST_DR_UPD   = 4'h5,
        ST_IR_SEL   = 4'h4,
        ST_IR_CAP   = 4'hE,
        ST_IR_SHIFT = 4'hA,
        ST_IR_EX1   = 4'h9,
        ST_IR_PAUSE = 4'hB,
        ST_IR_EX2   = 4'h8,
        ST_IR_UPD   = 4'hD
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_CLAMP    = 4'b0000;
    localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0001;
    localparam logic [IR_W-1:0] OP_EXPULSE  = 4'b0010;
    localparam logic [IR_W-1:0] OP_EXTRAIN  = 4'b0011;
    localparam logic [IR_W-1:0] OP_INTEST   = 4'b0100;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0101;
    localparam logic [IR_W-1:0] OP_HIGHZ    = 4'b0110;
    localparam logic [IR_W-1:0] OP_HOST     = 4'b0111;
    localparam logic [IR_W-1:0] OP_IDCODE   = 4'b1000;
    localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;

    typedef enum logic [1:0] {
        SRC_BYPASS = 2'd0,
        SRC_CHAIN  = 2'd1,
        SRC_HOST   = 2'd2,
        SRC_ID     = 2'd3
    } tdo_src_e;

    typedef struct packed {
        logic     chain_sel;
        logic     host_sel;
        logic     hold_off;
        logic     core_from_jtag;
        logic     pins_from_jtag;
        logic     pulse_mode;
        logic     train_mode;
        tdo_src_e tdo_src;
    } ir_decode_t;

endpackage

// File: rtl/tap_fsm.sv
// TMS-driven 16-state controller. Synchronous active-low reset on the
// rising edge of tck; assumes tms is stable around that edge.
module tap_fsm
    import tap_ctrl_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_e state
);

    tap_state_e nxt;

    // Next state from the current state and tms.
    always_comb begin
        unique case (state)
            ST_RESET:    nxt = tms ? ST_RESET    : ST_IDLE;
            ST_IDLE:     nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_DR_SEL:   nxt = tms ? ST_IR_SEL   : ST_DR_CAP;
            ST_DR_CAP:   nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_SHIFT: nxt = tms ? ST_DR_EX1   : ST_DR_SHIFT;
            ST_DR_EX1:   nxt = tms ? ST_DR_UPD   : ST_DR_PAUSE;
            ST_DR_PAUSE: nxt = tms ? ST_DR_EX2   : ST_DR_PAUSE;
            ST_DR_EX2:   nxt = tms ? ST_DR_UPD   : ST_DR_SHIFT;
            ST_DR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            ST_IR_SEL:   nxt = tms ? ST_RESET    : ST_IR_CAP;
            ST_IR_CAP:   nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_SHIFT: nxt = tms ? ST_IR_EX1   : ST_IR_SHIFT;
            ST_IR_EX1:   nxt = tms ? ST_IR_UPD   : ST_IR_PAUSE;
            ST_IR_PAUSE: nxt = tms ? ST_IR_EX2   : ST_IR_PAUSE;
            ST_IR_EX2:   nxt = tms ? ST_IR_UPD   : ST_IR_SHIFT;
            ST_IR_UPD:   nxt = tms ? ST_DR_SEL   : ST_IDLE;
            default:     nxt = ST_RESET;
        endcase
    end

    // State register with synchronous reset.
    always_ff @(posedge tck) begin
        if (!trst_n) state <= ST_RESET;
        else         state <= nxt;
    end

endmodule

// File: rtl/tap_ir.sv
// Instruction register: a shift stage loaded in Capture-IR and shifted in
// Shift-IR, plus a parallel stage loaded only when leaving Update-IR.
// Test-Logic-Reset reloads the parallel stage with RST_OP.
module tap_ir
    import tap_ctrl_pkg::*;
#(
    parameter int              W      = IR_W,
    parameter logic [W-1:0]    CAP_OP = IR_CAPTURE,
    parameter logic [W-1:0]    RST_OP = OP_IDCODE
) (
    input  logic         tck,
    input  logic         trst_n,
    input  tap_state_e   state,
    input  logic         tdi,
    output logic         ir_lsb,
    output logic [W-1:0] ir_q
);

    logic [W-1:0] ir_sr;

    // Shift stage: capture fixed pattern, shift toward LSB.
    always_ff @(posedge tck) begin
        if (!trst_n)                   ir_sr <= CAP_OP;
        else if (state == ST_IR_CAP)   ir_sr <= CAP_OP;
        else if (state == ST_IR_SHIFT) ir_sr <= {tdi, ir_sr[W-1:1]};
    end

    // Parallel stage: updated from the shift stage only in Update-IR.
    always_ff @(posedge tck) begin
        if (!trst_n || state == ST_RESET) ir_q <= RST_OP;
        else if (state == ST_IR_UPD)      ir_q <= ir_sr;
    end

    assign ir_lsb = ir_sr[0];

endmodule

// File: rtl/tap_dr.sv
// Internal data registers: one-bit bypass stage and an identification
// register. Both capture in Capture-DR and shift in Shift-DR; the TDO
// mux decides which one is observed.
module tap_dr
    import tap_ctrl_pkg::*;
#(
    parameter int            ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  tap_state_e state,
    input  logic       tdi,
    output logic       byp_q,
    output logic       id_lsb
);

    logic [ID_W-1:0] id_sr;

    // Bypass stage: capture zero, then one-bit delay of tdi.
    always_ff @(posedge tck) begin
        if (!trst_n)                   byp_q <= 1'b0;
        else if (state == ST_DR_CAP)   byp_q <= 1'b0;
        else if (state == ST_DR_SHIFT) byp_q <= tdi;
    end

    // ID register: capture constant, shift LSB first.
    always_ff @(posedge tck) begin
        if (!trst_n)                   id_sr <= ID_VALUE;
        else if (state == ST_DR_CAP)   id_sr <= ID_VALUE;
        else if (state == ST_DR_SHIFT) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end

    assign id_lsb = id_sr[0];

endmodule

// File: rtl/tap_decode.sv
// Combinational decode of the active instruction into boundary-scan
// controls and the TDO source. Undefined codes select bypass only.
module tap_decode
    import tap_ctrl_pkg::*;
(
    input  logic [IR_W-1:0] ir,
    output ir_decode_t      dec
);

    // One decode per opcode; defaults cover undefined codes.
    always_comb begin
        dec = '{chain_sel: 1'b0, host_sel: 1'b0, hold_off: 1'b0,
                core_from_jtag: 1'b0, pins_from_jtag: 1'b0,
                pulse_mode: 1'b0, train_mode: 1'b0, tdo_src: SRC_BYPASS};
        unique case (ir)
            OP_CLAMP:   dec.pins_from_jtag = 1'b1;
            OP_EXTEST: begin
                dec.chain_sel = 1'b1; dec.pins_from_jtag = 1'b1;
                dec.tdo_src = SRC_CHAIN;
            end
            OP_EXPULSE: begin
                dec.chain_sel = 1'b1; dec.pins_from_jtag = 1'b1;
                dec.pulse_mode = 1'b1; dec.tdo_src = SRC_CHAIN;
            end
            OP_EXTRAIN: begin
                dec.chain_sel = 1'b1; dec.pins_from_jtag = 1'b1;
                dec.train_mode = 1'b1; dec.tdo_src = SRC_CHAIN;
            end
            OP_INTEST: begin
                dec.chain_sel = 1'b1; dec.core_from_jtag = 1'b1;
                dec.tdo_src = SRC_CHAIN;
            end
            OP_SAMPLE: begin
                dec.chain_sel = 1'b1; dec.tdo_src = SRC_CHAIN;
            end
            OP_HIGHZ: begin
                dec.hold_off = 1'b1; dec.pins_from_jtag = 1'b1;
            end
            OP_HOST: begin
                dec.host_sel = 1'b1; dec.tdo_src = SRC_HOST;
            end
            OP_IDCODE:  dec.tdo_src = SRC_ID;
            default:    ;
        endcase
    end

endmodule

// File: rtl/tap_ctrl.sv
// Top of the test access port controller. Rising-edge state, instruction
// and data registers; TDO and its enable retimed on the falling edge.
// Assumes the boundary chain and host returns are stable in Shift-DR.
module tap_ctrl
    import tap_ctrl_pkg::*;
#(
    parameter int              ID_W     = 32,
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    input  logic       tdi,
    output logic       tdo,
    output logic       tdo_oe,
    input  logic       chain_ret,
    input  logic       host_ret,
    output logic       chain_sel,
    output logic       host_sel,
    output logic       chain_capture,
    output logic       chain_shift,
    output logic       chain_update,
    output logic       tlr_n,
    output logic [3:0] state_code,
    output logic       hold_off,
    output logic       core_from_jtag,
    output logic       pins_from_jtag,
    output logic       pulse_mode,
    output logic       train_mode
);

    tap_state_e      state;
    logic [IR_W-1:0] ir_q;
    logic            ir_lsb;
    logic            byp_q;
    logic            id_lsb;
    ir_decode_t      dec;
    logic            in_ir_path;
    logic            tdo_d;

    tap_fsm u_fsm (.tck(tck), .trst_n(trst_n), .tms(tms), .state(state));

    tap_ir #(.W(IR_W), .CAP_OP(IR_CAPTURE), .RST_OP(OP_IDCODE)) u_ir (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .ir_lsb(ir_lsb), .ir_q(ir_q)
    );

    tap_dr #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck(tck), .trst_n(trst_n), .state(state), .tdi(tdi),
        .byp_q(byp_q), .id_lsb(id_lsb)
    );

    tap_decode u_dec (.ir(ir_q), .dec(dec));

    // IR branch states after Select-IR route the instruction stage to TDO.
    always_comb begin
        unique case (state)
            ST_IR_CAP, ST_IR_SHIFT, ST_IR_EX1,
            ST_IR_PAUSE, ST_IR_EX2, ST_IR_UPD: in_ir_path = 1'b1;
            default:                           in_ir_path = 1'b0;
        endcase
    end

    // TDO source selection.
    always_comb begin
        if (in_ir_path) tdo_d = ir_lsb;
        else begin
            unique case (dec.tdo_src)
                SRC_CHAIN: tdo_d = chain_ret;
                SRC_HOST:  tdo_d = host_ret;
                SRC_ID:    tdo_d = id_lsb;
                default:   tdo_d = byp_q;
            endcase
        end
    end

    // Falling-edge retiming of serial output and its enable.
    always_ff @(negedge tck) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= tdo_d;
            tdo_oe <= (state == ST_DR_SHIFT) || (state == ST_IR_SHIFT);
        end
    end

    assign chain_sel      = dec.chain_sel;
    assign host_sel       = dec.host_sel;
    assign hold_off       = dec.hold_off;
    assign core_from_jtag = dec.core_from_jtag;
    assign pins_from_jtag = dec.pins_from_jtag;
    assign pulse_mode     = dec.pulse_mode;
    assign train_mode     = dec.train_mode;
    assign chain_capture  = dec.chain_sel && (state == ST_DR_CAP);
    assign chain_shift    = dec.chain_sel && (state == ST_DR_SHIFT);
    assign chain_update   = dec.chain_sel && (state == ST_DR_UPD);
    assign tlr_n          = (state != ST_RESET);
    assign state_code     = state;

endmodule

// File: rtl/tap_ctrl_chk.sv
// Property checker for tap_ctrl, attached by bind. Observes ports only.
module tap_ctrl_chk (
    input logic       tck,
    input logic       trst_n,
    input logic       tms,
    input logic       tdo_oe,
    input logic       chain_sel,
    input logic       host_sel,
    input logic       chain_capture,
    input logic       chain_shift,
    input logic       chain_update,
    input logic [3:0] state_code,
    input logic       hold_off,
    input logic       core_from_jtag,
    input logic       pins_from_jtag,
    input logic       pulse_mode,
    input logic       train_mode
);

    p_reset_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_code == 4'hF && tms) |=> (state_code == 4'hF));

    p_idle_hold_r1: assert property (@(posedge tck) disable iff (!trst_n)
        (state_code == 4'hC && !tms) |=> (state_code == 4'hC));

    p_ir_stable_r4: assert property (@(posedge tck) disable iff (!trst_n)
        (state_code != 4'hD && state_code != 4'hF) |=>
        $stable({chain_sel, host_sel, hold_off, core_from_jtag,
                 pins_from_jtag, pulse_mode, train_mode}));

    p_sel_exclusive_r8: assert property (@(posedge tck) disable iff (!trst_n)
        !(chain_sel && host_sel));

    p_strobe_qualified_r10: assert property (@(posedge tck) disable iff (!trst_n)
        (chain_capture || chain_shift || chain_update) |-> chain_sel);

    p_oe_in_shift_r11: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (state_code == 4'h2 || state_code == 4'hA));

endmodule

bind tap_ctrl tap_ctrl_chk chk_i (.*);

// File: tb/tap_ctrl_tb_top.sv
`timescale 1ns/1ps
module tap_ctrl_tb_top;

    logic tck = 1'b0;
    logic trst_n = 1'b0;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic chain_ret = 1'b1;
    logic host_ret = 1'b0;
    logic tdo, tdo_oe, chain_sel, host_sel, chain_capture, chain_shift;
    logic chain_update, tlr_n, hold_off, core_from_jtag, pins_from_jtag;
    logic pulse_mode, train_mode;
    logic [3:0] state_code;

    int n_chk = 0;
    int n_bad = 0;
    logic seen;
    logic [3:0] model;

    always #2.5 tck = ~tck;

    tap_ctrl dut_i (.*);

    // Reference state graph from the requirements (codes of R1).
    function automatic logic [3:0] ref_next(input logic [3:0] s, input logic m);
        case (s)
            4'hF: return m ? 4'hF : 4'hC;
            4'hC: return m ? 4'h7 : 4'hC;
            4'h7: return m ? 4'h4 : 4'h6;
            4'h6: return m ? 4'h1 : 4'h2;
            4'h2: return m ? 4'h1 : 4'h2;
            4'h1: return m ? 4'h5 : 4'h3;
            4'h3: return m ? 4'h0 : 4'h3;
            4'h0: return m ? 4'h5 : 4'h2;
            4'h5: return m ? 4'h7 : 4'hC;
            4'h4: return m ? 4'hF : 4'hE;
            4'hE: return m ? 4'h9 : 4'hA;
            4'hA: return m ? 4'h9 : 4'hA;
            4'h9: return m ? 4'hD : 4'hB;
            4'hB: return m ? 4'h8 : 4'hB;
            4'h8: return m ? 4'hD : 4'hA;
            default: return m ? 4'h7 : 4'hC;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One tck cycle: drive, read tdo, pass rising and falling edges.
    task automatic step(input logic m, input logic d);
        tms = m; tdi = d; seen = tdo;
        @(posedge tck); @(negedge tck); #1;
    endtask

    // Decode vector expected for an opcode (R8, R9).
    function automatic logic [6:0] exp_dec(input logic [3:0] op);
        logic bs, hs, fd, ji, jo, pu, tr;
        bs = (op >= 4'd1 && op <= 4'd5);
        hs = (op == 4'd7);
        fd = (op == 4'd6);
        ji = (op == 4'd4);
        jo = (op <= 4'd3) || (op == 4'd6);
        pu = (op == 4'd2);
        tr = (op == 4'd3);
        return {bs, hs, fd, ji, jo, pu, tr};
    endfunction

    function automatic logic [6:0] act_dec();
        return {chain_sel, host_sel, hold_off, core_from_jtag,
                pins_from_jtag, pulse_mode, train_mode};
    endfunction

    // Load an opcode from Run-Test/Idle and return there.
    task automatic ir_load(input logic [3:0] op, input logic [3:0] prev);
        logic [3:0] got;
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        chk("R11 oe in Shift-IR", tdo_oe, 1'b1);
        for (int i = 0; i < 4; i++) begin
            step(i == 3, op[i]);
            got[i] = seen;
        end
        chk("R3 IR capture pattern", got, 4'b0001);
        chk("R4 decode held before Update-IR", act_dec(), exp_dec(prev));
        step(1, 0);
        step(0, 0);
        chk("R1 back in idle", state_code, 4'hC);
    endtask

    // Eight-bit DR scan from idle; checks chain strobes on the way.
    task automatic dr_scan(input logic [7:0] pat, input logic bsel, output logic [7:0] got);
        step(1, 0); step(0, 0);
        chk("R10 capture strobe", chain_capture, bsel);
        step(0, 0);
        chk("R10 shift strobe", chain_shift, bsel);
        chk("R11 oe in Shift-DR", tdo_oe, 1'b1);
        for (int i = 0; i < 8; i++) begin
            step(i == 7, pat[i]);
            got[i] = seen;
        end
        chk("R11 oe off after shift", tdo_oe, 1'b0);
        step(1, 0);
        chk("R10 update strobe", chain_update, bsel);
        step(0, 0);
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [7:0] got;
        logic [7:0] expv;
        logic [15:0] lfsr;
        logic [3:0] prev;
        @(negedge tck); #1;
        repeat (3) step(1, 0);
        // Reset state.
        chk("R1 reset state code", state_code, 4'hF);
        chk("R12 tlr_n in reset", tlr_n, 1'b0);
        chk("R11 oe low in reset", tdo_oe, 1'b0);
        trst_n = 1'b1;
        step(0, 0);
        chk("R12 tlr_n out of reset", tlr_n, 1'b1);
        chk("R2 reset instruction decode", act_dec(), exp_dec(4'b1000));
        dr_scan(8'hA5, 1'b0, got);
        chk("R7 ID register low byte", got, 8'h01);

        // Pseudo-random TMS walk against the reference graph.
        model = 4'hC;
        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            logic m;
            m = lfsr[0];
            lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
            if (model == 4'hD) m = 1'b1;
            step(m, 0);
            model = ref_next(model, m);
            chk("R1 state walk", state_code, model);
            chk("R12 tlr_n walk", tlr_n, model != 4'hF);
            if (k % 37 == 36) begin
                for (int j = 0; j < 5; j++) step(1, 0);
                chk("R2 five tms highs", state_code, 4'hF);
                model = 4'hF;
            end
        end
        for (int j = 0; j < 5; j++) step(1, 0);
        step(0, 0);

        // Every opcode: decode and TDO source.
        prev = 4'b1000;
        for (int o = 0; o < 16; o++) begin
            logic [3:0] op;
            op = o[3:0];
            ir_load(op, prev);
            prev = op;
            chk($sformatf("R8 R9 decode op %0h", op), act_dec(), exp_dec(op));
            dr_scan(8'b1011_0010, exp_dec(op)[6], got);
            if (op >= 4'd1 && op <= 4'd5) expv = 8'hFF;
            else if (op == 4'd7) expv = 8'h00;
            else if (op == 4'd8) expv = 8'h01;
            else expv = {7'b0110_010, 1'b0};
            chk($sformatf("R5 R6 tdo path op %0h", op), got, expv);
        end

        // Reset in the middle of a scan restores IDCODE.
        ir_load(4'b0001, 4'b1111);
        step(1, 0); step(0, 0); step(0, 0);
        trst_n = 1'b0;
        step(0, 0);
        chk("R2 trst in Shift-DR", state_code, 4'hF);
        trst_n = 1'b1;
        step(0, 0);
        chk("R2 trst reloads IDCODE", act_dec(), exp_dec(4'b1000));
        dr_scan(8'h00, 1'b0, got);
        chk("R7 ID after trst", got, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule